// File: doc/BRIEF.md
# ARC4 Stream Cipher Engine with State Save and Restore

The engine builds a 256-entry byte permutation and XORs each accepted message byte with the next ARC4 keystream byte. A permutation can be built in two ways. The first is a key schedule that reads a key of 1 to 16 bytes held in two 64-bit key words. The second skips the schedule and loads a permutation with its two indices that were saved earlier, so an interrupted stream can carry on where it stopped. Each step of the key schedule and each keystream byte takes one clock cycle.

A run begins with a `start` pulse, which captures the mode, the key size and the message length. Message bytes then enter through a valid/ready pair, and each result byte leaves one cycle after its input byte is accepted. When the last byte has been processed, `done` rises. The full state can then be dumped on request. It leaves either on a dedicated context port or on the normal output byte stream, as chosen by a select input. The dump can be loaded back later to resume the same keystream.

Top module: `arc4_engine`

## Requirements
- R1: After reset `done`, `keyErr`, `inReady`, `ctxReady`, `outValid` and `ctxDumpValid` are all 0.
- R2: Key byte n (0 to 7) is `keyReg0[8n+7:8n]` and key byte 8+n is `keyReg1[8n+7:8n]`. The schedule cycles through bytes 0 to `keySize`-1 across its 256 steps. Bytes at or above `keySize` have no effect on the output.
- R3: A `start` in key-schedule mode with `keySize` equal to 0 or greater than 16 sets `keyErr` one cycle later. The engine then stays idle, with `inReady` and `done` held at 0. `keyErr` is cleared by the next accepted `start`.
- R4: In key-schedule mode, `inReady` (or `done`, when the message length is 0) rises 257 clock edges after the edge that accepts `start`.
- R5: Each byte accepted while `inValid` and `inReady` are both high appears on `outByte`, with `outValid` high, one cycle later. Its value is the input byte XOR the next ARC4 keystream byte (i=i+1, j=j+S[i], swap S[i] and S[j], output S[S[i]+S[j]]).
- R6: `done` rises one cycle after the `msgLen`-th byte is accepted. A `msgLen` of 0 gives `done` directly after the schedule or the load. At `done`, `inReady` falls.
- R7: In restore mode (`restoreMode`=1) the engine skips the key schedule and ignores `keySize`, and `keyErr` stays 0. While `ctxReady` is high it takes 258 bytes on the load port: S[0] to S[255], then i, then j.
- R8: A `dumpReq` while `done` is high sends out 258 bytes, one per cycle starting one cycle after the request, in the same order as R7. They leave on `ctxDumpByte` when `dumpToStream`=0, and on `outByte`/`outValid` when it is 1.
- R9: A `dumpReq` while `done` is low has no effect: no dump byte appears on either port.
- R10: If a dumped state is loaded back, the stream continues exactly as if the original run had gone on without a break.
- R11: A `start` that arrives while a schedule, load, message or dump is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| restoreMode | input | 1 | 1 selects state load, 0 selects key schedule |
| keySize | input | 5 | Number of key bytes in use |
| keyReg0 | input | 64 | Key bytes 0 to 7 |
| keyReg1 | input | 64 | Key bytes 8 to 15 |
| msgLen | input | 16 | Number of message bytes in the run |
| inValid | input | 1 | Message byte valid |
| inByte | input | 8 | Message byte |
| inReady | output | 1 | Engine accepts a message byte |
| outValid | output | 1 | Result or dump byte valid on outByte |
| outByte | output | 8 | Ciphered byte or streamed dump byte |
| ctxReady | output | 1 | Engine accepts a state load byte |
| ctxLoadValid | input | 1 | State load byte valid |
| ctxLoadByte | input | 8 | State load byte |
| dumpReq | input | 1 | Request a state dump |
| dumpToStream | input | 1 | 1 sends the dump on outByte, 0 sends it on the context port |
| ctxDumpValid | output | 1 | Dump byte valid on ctxDumpByte |
| ctxDumpByte | output | 8 | Dump byte |
| done | output | 1 | Run complete; state can be dumped |
| keyErr | output | 1 | Rejected key size |

## Verification
The keystream depends on every entry of the permutation and on both indices, so a wrong swap, a wrong index update or a misread key byte shows up on `outByte`. It appears at the first byte that touches the damaged entry, which is normally within the first few bytes of a message. A timing fault in the schedule or load counters shows as `inReady` or `done` arriving on the wrong edge. A fault in the state path shows in two ways: the dumped bytes differ from a reference permutation, and a resumed stream differs from an unbroken one at its first byte.

// File: rtl/arc4_pkg.sv
package arc4_pkg;
  localparam int KEY_WORD_BYTES = 8;
  localparam int KEY_BYTES      = 2 * KEY_WORD_BYTES;
  localparam int KEY_POS_W      = $clog2(KEY_BYTES);
  localparam int KEY_SIZE_W     = $clog2(KEY_BYTES + 1);
  localparam int SBOX_N         = 256;
  localparam int CTX_N          = SBOX_N + 2;
  localparam int IDX_W          = $clog2(CTX_N);

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_KSA, ST_LOAD, ST_RUN, ST_DONE, ST_DUMP
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 initS;
    logic                 ksaStep;
    logic                 lastStep;
    logic                 prgaStep;
    logic                 loadByte;
    logic                 dumpStep;
    logic                 dumpToStream;
    logic [IDX_W-1:0]     idx;
    logic [KEY_POS_W-1:0] keyPos;
  } ctrl_t;
endpackage

// File: rtl/arc4_ctrl.sv
module arc4_ctrl
  import arc4_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  restoreMode,
  input  logic [KEY_SIZE_W-1:0] keySize,
  input  logic [LEN_W-1:0]      msgLen,
  input  logic                  inValid,
  input  logic                  ctxLoadValid,
  input  logic                  dumpReq,
  input  logic                  dumpToStream,
  output ctrl_t                 ctrl,
  output logic                  inReady,
  output logic                  ctxReady,
  output logic                  done,
  output logic                  keyErr
);
  localparam logic [IDX_W-1:0] LAST_SBOX = IDX_W'(SBOX_N - 1);
  localparam logic [IDX_W-1:0] LAST_CTX  = IDX_W'(CTX_N - 1);

  state_e                state;
  logic [IDX_W-1:0]      cnt;
  logic [KEY_POS_W-1:0]  keyPos;
  logic [KEY_SIZE_W-1:0] keySizeQ;
  logic [LEN_W-1:0]      remain;
  logic                  dumpStreamQ;
  logic                  canStart;
  logic                  badKey;

  assign canStart = start && (state == ST_IDLE || state == ST_DONE);
  assign badKey   = (keySize == '0) || (keySize > KEY_SIZE_W'(KEY_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      keyPos      <= '0;
      keySizeQ    <= '0;
      remain      <= '0;
      dumpStreamQ <= 1'b0;
      keyErr      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (canStart) begin
            keyErr   <= badKey && !restoreMode;
            keySizeQ <= keySize;
            remain   <= msgLen;
            cnt      <= '0;
            keyPos   <= '0;
            if (restoreMode)  state <= ST_LOAD;
            else if (badKey)  state <= ST_IDLE;
            else              state <= ST_INIT;
          end else if (state == ST_DONE && dumpReq) begin
            state       <= ST_DUMP;
            cnt         <= '0;
            dumpStreamQ <= dumpToStream;
          end
        end
        ST_INIT: state <= ST_KSA;
        ST_KSA: begin
          cnt    <= cnt + 1'b1;
          keyPos <= (KEY_SIZE_W'(keyPos) + KEY_SIZE_W'(1) == keySizeQ) ? '0 : keyPos + 1'b1;
          if (cnt == LAST_SBOX) state <= (remain == '0) ? ST_DONE : ST_RUN;
        end
        ST_LOAD: begin
          if (ctxLoadValid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_CTX) state <= (remain == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (inValid) begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) state <= ST_DONE;
          end
        end
        ST_DUMP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CTX) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady  = (state == ST_RUN);
  assign ctxReady = (state == ST_LOAD);
  assign done     = (state == ST_DONE) || (state == ST_DUMP);

  always_comb begin
    ctrl              = '0;
    ctrl.initS        = (state == ST_INIT);
    ctrl.ksaStep      = (state == ST_KSA);
    ctrl.lastStep     = (state == ST_KSA) && (cnt == LAST_SBOX);
    ctrl.prgaStep     = (state == ST_RUN) && inValid;
    ctrl.loadByte     = (state == ST_LOAD) && ctxLoadValid;
    ctrl.dumpStep     = (state == ST_DUMP);
    ctrl.dumpToStream = dumpStreamQ;
    ctrl.idx          = cnt;
    ctrl.keyPos       = keyPos;
  end

  // R3
  bad_key_stalls_chk: assert property (@(posedge clk) disable iff (!rstN)
    canStart && !restoreMode && badKey |=> keyErr && !inReady && !done);
  // R4
  ksa_runs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_KSA && cnt != LAST_SBOX |=> state == ST_KSA);
  // R6
  last_byte_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady && inValid && remain == LEN_W'(1) |=> done && !inReady);
  // R9
  no_early_dump_chk: assert property (@(posedge clk) disable iff (!rstN)
    dumpReq && !done |=> state != ST_DUMP);
endmodule

// File: rtl/arc4_datapath.sv
module arc4_datapath
  import arc4_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_t                  ctrl,
  input  logic [8*KEY_BYTES-1:0] keyAll,
  input  logic [7:0]             inByte,
  input  logic [7:0]             ctxLoadByte,
  output logic                   outValid,
  output logic [7:0]             outByte,
  output logic                   ctxDumpValid,
  output logic [7:0]             ctxDumpByte
);
  logic [7:0] sbox [SBOX_N];
  logic [7:0] idxI, idxJ;
  logic [7:0] kIdx, keyByte, ksaJ;
  logic [7:0] pI, pJ, pSi, pSj, pT, ksB, dumpB;

  always_comb begin
    kIdx    = ctrl.idx[7:0];
    keyByte = keyAll[{ctrl.keyPos, 3'b000} +: 8];
    ksaJ    = idxJ + sbox[kIdx] + keyByte;
    pI      = idxI + 8'd1;
    pSi     = sbox[pI];
    pJ      = idxJ + pSi;
    pSj     = sbox[pJ];
    pT      = pSi + pSj;
    // read the post-swap permutation
    if (pT == pI)      ksB = pSj;
    else if (pT == pJ) ksB = pSi;
    else               ksB = sbox[pT];
    if (ctrl.idx < IDX_W'(SBOX_N))       dumpB = sbox[kIdx];
    else if (ctrl.idx == IDX_W'(SBOX_N)) dumpB = idxI;
    else                                 dumpB = idxJ;
  end

  always_ff @(posedge clk) begin
    if (ctrl.initS) begin
      for (int n = 0; n < SBOX_N; n++) sbox[n] <= 8'(n);
    end else if (ctrl.ksaStep) begin
      sbox[kIdx] <= sbox[ksaJ];
      sbox[ksaJ] <= sbox[kIdx];
    end else if (ctrl.prgaStep) begin
      sbox[pI] <= pSj;
      sbox[pJ] <= pSi;
    end else if (ctrl.loadByte && ctrl.idx < IDX_W'(SBOX_N)) begin
      sbox[kIdx] <= ctxLoadByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxI         <= '0;
      idxJ         <= '0;
      outValid     <= 1'b0;
      outByte      <= '0;
      ctxDumpValid <= 1'b0;
      ctxDumpByte  <= '0;
    end else begin
      if (ctrl.initS) begin
        idxI <= '0;
        idxJ <= '0;
      end else if (ctrl.ksaStep) begin
        idxJ <= ctrl.lastStep ? 8'd0 : ksaJ;
      end else if (ctrl.prgaStep) begin
        idxI <= pI;
        idxJ <= pJ;
      end else if (ctrl.loadByte && ctrl.idx == IDX_W'(SBOX_N)) begin
        idxI <= ctxLoadByte;
      end else if (ctrl.loadByte && ctrl.idx == IDX_W'(SBOX_N + 1)) begin
        idxJ <= ctxLoadByte;
      end
      outValid     <= ctrl.prgaStep || (ctrl.dumpStep && ctrl.dumpToStream);
      outByte      <= ctrl.prgaStep ? (inByte ^ ksB) : dumpB;
      ctxDumpValid <= ctrl.dumpStep && !ctrl.dumpToStream;
      ctxDumpByte  <= dumpB;
    end
  end

  // R5
  prga_advances_i_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.prgaStep |=> idxI == $past(idxI) + 8'd1 && outValid);
  // R4
  ksa_end_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lastStep |=> idxI == 8'd0 && idxJ == 8'd0);
  // R7
  load_j_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadByte && ctrl.idx == IDX_W'(SBOX_N + 1) |=> idxJ == $past(ctxLoadByte));
endmodule

// File: rtl/arc4_engine.sv
module arc4_engine
  import arc4_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  restoreMode,
  input  logic [KEY_SIZE_W-1:0] keySize,
  input  logic [63:0]           keyReg0,
  input  logic [63:0]           keyReg1,
  input  logic [LEN_W-1:0]      msgLen,
  input  logic                  inValid,
  input  logic [7:0]            inByte,
  output logic                  inReady,
  output logic                  outValid,
  output logic [7:0]            outByte,
  output logic                  ctxReady,
  input  logic                  ctxLoadValid,
  input  logic [7:0]            ctxLoadByte,
  input  logic                  dumpReq,
  input  logic                  dumpToStream,
  output logic                  ctxDumpValid,
  output logic [7:0]            ctxDumpByte,
  output logic                  done,
  output logic                  keyErr
);
  ctrl_t ctrl;

  arc4_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk, .rstN, .start, .restoreMode, .keySize, .msgLen, .inValid,
    .ctxLoadValid, .dumpReq, .dumpToStream, .ctrl, .inReady, .ctxReady,
    .done, .keyErr
  );

  arc4_datapath i_datapath (
    .clk, .rstN, .ctrl, .keyAll({keyReg1, keyReg0}), .inByte, .ctxLoadByte,
    .outValid, .outByte, .ctxDumpValid, .ctxDumpByte
  );
endmodule

// File: tb/test_arc4_engine.sv
module test_arc4_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, restoreMode = 0, inValid = 0, ctxLoadValid = 0;
  logic dumpReq = 0, dumpToStream = 0;
  logic [4:0] keySize = '0;
  logic [63:0] keyReg0 = '0, keyReg1 = '0;
  logic [15:0] msgLen = '0;
  logic [7:0] inByte = '0, ctxLoadByte = '0;
  logic inReady, outValid, ctxReady, ctxDumpValid, done, keyErr;
  logic [7:0] outByte, ctxDumpByte;

  arc4_engine i_arc4_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nErr = 0;
  logic [7:0] mS [256];
  logic [7:0] mI, mJ;
  logic [7:0] saved [258];
  logic [7:0] lastOut [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mKsa(input logic [127:0] key, input int size);
    logic [7:0] jj, t;
    for (int n = 0; n < 256; n++) mS[n] = 8'(n);
    jj = 0;
    for (int n = 0; n < 256; n++) begin
      jj = jj + mS[n] + key[8*(n % size) +: 8];
      t = mS[n]; mS[n] = mS[jj]; mS[jj] = t;
    end
    mI = 0; mJ = 0;
  endtask

  task automatic mStep(input logic [7:0] b, output logic [7:0] o);
    logic [7:0] t;
    mI = mI + 8'd1;
    mJ = mJ + mS[mI];
    t = mS[mI]; mS[mI] = mS[mJ]; mS[mJ] = t;
    o = b ^ mS[8'(mS[mI] + mS[mJ])];
  endtask

  task automatic doStart(input bit rest, input int ks, input int len);
    @(negedge clk);
    start = 1; restoreMode = rest; keySize = 5'(ks); msgLen = 16'(len);
    @(posedge clk);
    @(negedge clk);
    start = 0; restoreMode = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input string req, input int k);
    logic [7:0] exp;
    inValid = 1; inByte = b;
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    mStep(b, exp);
    if (k < 16) lastOut[k] = outByte;
    chk(outValid && outByte == exp, req, {outValid, outByte}, {1'b1, exp});
  endtask

  task automatic sendMsg(input int len);
    for (int k = 0; k < len; k++) sendByte(8'($urandom), "R5", k);
    chk(done && !inReady, "R6", {done, inReady}, 2'b10);
  endtask

  // keyed run: checks schedule latency, data and done
  task automatic runKeyed(input logic [63:0] k0, input logic [63:0] k1, input int ks,
                          input int len, input bit midStart);
    int n;
    keyReg0 = k0; keyReg1 = k1;
    doStart(0, ks, len);
    n = 0;
    while (!(inReady || done) && n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 50 && midStart) begin start = 1; restoreMode = 1; keySize = 0; end
      else begin start = 0; restoreMode = 0; end
    end
    chk(n == 257, midStart ? "R11" : "R4", n, 257);
    if (midStart) chk(!keyErr && !ctxReady, "R11", {keyErr, ctxReady}, 0);
    mKsa({k1, k0}, ks);
    sendMsg(len);
  endtask

  task automatic dump(input bit toStream);
    logic [7:0] exp;
    @(negedge clk);
    dumpReq = 1; dumpToStream = toStream;
    @(posedge clk);
    @(negedge clk);
    dumpReq = 0;
    for (int k = 0; k < 258; k++) begin
      exp = (k < 256) ? mS[k] : (k == 256) ? mI : mJ;
      @(posedge clk);
      @(negedge clk);
      if (toStream) begin
        saved[k] = outByte;
        chk(outValid && !ctxDumpValid && outByte == exp, "R8", outByte, exp);
      end else begin
        saved[k] = ctxDumpByte;
        chk(ctxDumpValid && !outValid && ctxDumpByte == exp, "R8", ctxDumpByte, exp);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(!ctxDumpValid && !outValid && done, "R8", {ctxDumpValid, outValid, done}, 3'b001);
  endtask

  task automatic loadCtx();
    chk(ctxReady && !keyErr, "R7", {ctxReady, keyErr}, 2'b10);
    for (int k = 0; k < 258; k++) begin
      ctxLoadValid = 1; ctxLoadByte = saved[k];
      @(posedge clk);
      @(negedge clk);
    end
    ctxLoadValid = 0;
  endtask

  task automatic noDumpWindow(input string req);
    @(negedge clk);
    dumpReq = 1;
    @(posedge clk);
    @(negedge clk);
    dumpReq = 0;
    for (int k = 0; k < 4; k++) begin
      chk(!ctxDumpValid && !outValid, req, {ctxDumpValid, outValid}, 0);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [7:0] pt [9];
    logic [7:0] ct [9];
    logic [7:0] ref9 [9];
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    pt  = '{8'h50, 8'h6C, 8'h61, 8'h69, 8'h6E, 8'h74, 8'h65, 8'h78, 8'h74};
    ct  = '{8'hBB, 8'hF3, 8'h16, 8'hE8, 8'hD9, 8'h40, 8'hAF, 8'h0A, 8'hD3};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!done && !keyErr && !inReady && !ctxReady && !outValid && !ctxDumpValid, "R1",
        {done, keyErr, inReady, ctxReady, outValid, ctxDumpValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!done && !inReady, "R1", {done, inReady}, 0);

    // R9: dump request while idle
    noDumpWindow("R9");

    // R2/R5: known vector, key "Key" in bytes 0..2 of keyReg0
    keyReg0 = 64'h0000_0000_0079_654B; keyReg1 = '0;
    doStart(0, 3, 9);
    while (!inReady) @(negedge clk);
    mKsa({keyReg1, keyReg0}, 3);
    for (int k = 0; k < 9; k++) begin
      sendByte(pt[k], "R5", k);
      chk(lastOut[k] == ct[k], "R5", lastOut[k], ct[k]);
    end
    chk(done, "R6", done, 1);

    // R2: bytes beyond keySize are ignored
    for (int k = 0; k < 9; k++) ref9[k] = lastOut[k];
    keyReg0 = 64'hDEAD_BEEF_A579_654B; keyReg1 = 64'h0123_4567_89AB_CDEF;
    doStart(0, 3, 9);
    while (!inReady) @(negedge clk);
    mKsa({keyReg1, keyReg0}, 3);
    for (int k = 0; k < 9; k++) begin
      sendByte(pt[k], "R2", k);
      chk(lastOut[k] == ref9[k], "R2", lastOut[k], ref9[k]);
    end

    // R3: bad key sizes
    doStart(0, 0, 4);
    chk(keyErr && !inReady && !done, "R3", {keyErr, inReady, done}, 3'b100);
    repeat (5) @(negedge clk);
    chk(keyErr && !inReady && !done, "R3", {keyErr, inReady, done}, 3'b100);
    noDumpWindow("R9");
    doStart(0, 17, 4);
    chk(keyErr && !inReady, "R3", {keyErr, inReady}, 2'b10);

    // R4/R11: keyed run with a start pulse during the schedule
    runKeyed({$urandom, $urandom}, {$urandom, $urandom}, 16, 6, 1'b1);
    chk(!keyErr, "R3", keyErr, 0);

    // R2/R4/R5/R6: random keyed runs incl. a full 16-byte key and empty messages
    for (int r = 0; r < 6; r++) begin
      int ks;
      ks = (r == 0) ? 16 : (r == 1) ? 1 : 1 + int'($urandom % 16);
      runKeyed({$urandom, $urandom}, {$urandom, $urandom}, ks,
               (r == 2) ? 0 : 1 + int'($urandom % 24), 1'b0);
    end

    // R8/R10: dump to context port, resume in restore mode
    runKeyed({$urandom, $urandom}, {$urandom, $urandom}, 1 + int'($urandom % 16), 20, 1'b0);
    dump(1'b0);
    doStart(1, 0, 15);
    loadCtx();
    chk(inReady, "R7", inReady, 1);
    for (int k = 0; k < 15; k++) sendByte(8'($urandom), "R10", k);
    chk(done, "R6", done, 1);

    // R8/R10: dump on the byte stream, resume again
    dump(1'b1);
    doStart(1, 31, 10);
    loadCtx();
    for (int k = 0; k < 10; k++) sendByte(8'($urandom), "R10", k);

    // R7: load an arbitrary permutation with random indices, empty message
    for (int n = 0; n < 256; n++) saved[n] = 8'(n);
    for (int n = 255; n > 0; n--) begin
      int m; logic [7:0] t;
      m = int'($urandom % (n + 1));
      t = saved[n]; saved[n] = saved[m]; saved[m] = t;
    end
    saved[256] = 8'($urandom); saved[257] = 8'($urandom);
    for (int n = 0; n < 256; n++) mS[n] = saved[n];
    mI = saved[256]; mJ = saved[257];
    doStart(1, 0, 0);
    loadCtx();
    chk(done && !inReady, "R6", {done, inReady}, 2'b10);
    dump(1'b0);
    doStart(1, 0, 12);
    loadCtx();
    for (int k = 0; k < 12; k++) sendByte(8'($urandom), "R7", k);

    // R11: start during a dump is ignored
    @(negedge clk);
    dumpReq = 1; dumpToStream = 0;
    @(posedge clk);
    @(negedge clk);
    dumpReq = 0; start = 1; restoreMode = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0; restoreMode = 0;
    chk(!ctxReady && ctxDumpValid, "R11", {ctxReady, ctxDumpValid}, 2'b01);
    repeat (260) @(negedge clk);
    chk(done && !ctxDumpValid, "R11", {done, ctxDumpValid}, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule